// File: doc/BRIEF.md
# I2C Master Bus-Error Timeout Watchdog

This block watches an I2C master's attempts to put a START or a STOP condition on the bus, and raises a sticky interrupt flag when the attempt does not complete in time. Software programs an 8-bit setting. The allowed window is that setting plus one, counted in bit periods. A separate bit-rate generator supplies the bit period as a one-cycle tick.

A START attempt is measured only while the bus is occupied. The bus is occupied when SCL is sampled low, or when another master has opened a transaction that it has not yet closed. A STOP attempt is measured on every bit period until the bus logic reports that it has seen the STOP. When a request arrives while a byte is still being shifted, the watchdog does not arm yet. It waits for the strobe that marks the end of the acknowledge bit's low phase and arms on that strobe.

Successful completion of the attempt stops and clears the count, and in that case no flag is raised. A setting of zero turns the watchdog off.

Top module: `i2c_tmo_watch`

## Requirements
- R1: With setting L (1 to 255) and a START pending on an occupied bus, `tmo_irq` rises one cycle after the (L+1)-th counted `bit_tick`. It is still low after L counted ticks.
- R2: When `tmo_limit` is 0, requests are ignored and `tmo_irq` never rises, whatever the number of ticks.
- R3: A START request made with `xfer_active` low arms the watchdog at once. Ticks that arrive while the bus is free (`scl_in` high and `other_busy` low) are not counted.
- R4: The bus counts as occupied when either `scl_in` is 0 or `other_busy` is 1. Each condition alone is enough for ticks to count.
- R5: A START request made with `xfer_active` high counts no ticks until `ack_low_end` pulses. From that pulse on, it behaves as in R1.
- R6: A STOP request made with `xfer_active` high counts no ticks until `ack_low_end` pulses. From that pulse on, it behaves as in R7.
- R7: A pending STOP counts every `bit_tick`, whatever the bus state. With setting L, `tmo_irq` rises after L+1 ticks unless `stop_seen` pulses first.
- R8: `start_done` (for a pending START) or `stop_seen` (for a pending STOP) returns the watchdog to idle with its count cleared, and no flag is raised. This also holds when the completion arrives in the same cycle as the terminal tick.
- R9: `tmo_irq` stays set until `tmo_clr` is high. When `tmo_clr` and a timeout happen in the same cycle, the flag ends up set.
- R10: After a synchronous reset, `tmo_irq` is 0 and no attempt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_limit | input | 8 | Timeout setting; window is setting+1 bit periods, 0 disables |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| start_req | input | 1 | Pulse: master asks to generate a START |
| stop_req | input | 1 | Pulse: master asks to generate a STOP |
| other_busy | input | 1 | Another master's transaction is open on the bus |
| scl_in | input | 1 | Synchronized SCL level |
| xfer_active | input | 1 | A byte is being shifted (past first bit's rising edge) |
| ack_low_end | input | 1 | Pulse: low phase of the acknowledge bit has ended |
| start_done | input | 1 | Pulse: START condition was generated |
| stop_seen | input | 1 | Pulse: STOP condition was observed on the bus |
| tmo_clr | input | 1 | Clears the timeout flag |
| tmo_irq | output | 1 | Sticky timeout flag (registered) |

## Verification
The assertions assume that requests, completions and `ack_low_end` are single-cycle pulses. They also assume that `tmo_limit` does not change while an attempt is pending. The bench drives every pulse for exactly one cycle and changes the setting only when the watchdog is idle. It also waits for each attempt to end, either by timing out or by completing, before it issues the next request. Input changes are made on the falling clock edge, so every input is stable around the rising edge that samples it.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE       = 3'd0,
    SQ_HOLD_START = 3'd1,
    SQ_HOLD_STOP  = 3'd2,
    SQ_RUN_START  = 3'd3,
    SQ_RUN_STOP   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/tmo_tick_cnt.sv
module tmo_tick_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  // terminal when the tick that would make the count limit+1 arrives
  assign hit = adv && (cnt_q == limit);
  assign cnt = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (adv && (cnt_q != limit)) begin
      cnt_q <= cnt_q + 1'b1;  // saturates at limit
    end
  end
endmodule

// File: rtl/tmo_seq.sv
module tmo_seq
  import i2c_tmo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       limit_zero,
  input  logic       start_req,
  input  logic       stop_req,
  input  logic       xfer_active,
  input  logic       ack_low_end,
  input  logic       bus_busy,
  input  logic       bit_tick,
  input  logic       start_done,
  input  logic       stop_seen,
  input  logic       hit,
  output seq_state_e state,
  output logic       adv,
  output logic       clr_cnt,
  output logic       expire
);
  seq_state_e st_q, st_n;
  logic run_start, run_stop, done;

  assign run_start = (st_q == SQ_RUN_START);
  assign run_stop  = (st_q == SQ_RUN_STOP);
  assign done = ((run_start || st_q == SQ_HOLD_START) && start_done) ||
                ((run_stop  || st_q == SQ_HOLD_STOP)  && stop_seen);
  assign adv    = bit_tick && ((run_start && bus_busy) || run_stop);
  assign expire = (run_start || run_stop) && hit && !done && !limit_zero;
  assign state  = st_q;

  always_comb begin
    st_n = st_q;
    if (limit_zero) begin
      st_n = SQ_IDLE;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (start_req)     st_n = xfer_active ? SQ_HOLD_START : SQ_RUN_START;
          else if (stop_req) st_n = xfer_active ? SQ_HOLD_STOP  : SQ_RUN_STOP;
        end
        SQ_HOLD_START: begin
          if (done)             st_n = SQ_IDLE;
          else if (ack_low_end) st_n = SQ_RUN_START;
        end
        SQ_HOLD_STOP: begin
          if (done)             st_n = SQ_IDLE;
          else if (ack_low_end) st_n = SQ_RUN_STOP;
        end
        SQ_RUN_START, SQ_RUN_STOP: begin
          if (done || hit) st_n = SQ_IDLE;
        end
        default: st_n = SQ_IDLE;
      endcase
    end
  end

  assign clr_cnt = (st_n != SQ_RUN_START) && (st_n != SQ_RUN_STOP);

  always_ff @(posedge clk) begin
    if (rst) st_q <= SQ_IDLE;
    else     st_q <= st_n;
  end
endmodule

// File: rtl/tmo_sticky.sv
module tmo_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;   // set beats clear
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/i2c_tmo_watch.sv
module i2c_tmo_watch
  import i2c_tmo_pkg::*;
#(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] tmo_limit,
  input  logic             bit_tick,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             other_busy,
  input  logic             scl_in,
  input  logic             xfer_active,
  input  logic             ack_low_end,
  input  logic             start_done,
  input  logic             stop_seen,
  input  logic             tmo_clr,
  output logic             tmo_irq
);
  seq_state_e       seq_st;
  logic             bus_busy, limit_zero, adv, clr_cnt, hit, expire;
  logic [SET_W-1:0] cnt;

  assign bus_busy   = other_busy || !scl_in;
  assign limit_zero = (tmo_limit == '0);

  tmo_seq u_seq (
    .clk(clk), .rst(rst), .limit_zero(limit_zero),
    .start_req(start_req), .stop_req(stop_req),
    .xfer_active(xfer_active), .ack_low_end(ack_low_end),
    .bus_busy(bus_busy), .bit_tick(bit_tick),
    .start_done(start_done), .stop_seen(stop_seen), .hit(hit),
    .state(seq_st), .adv(adv), .clr_cnt(clr_cnt), .expire(expire)
  );

  tmo_tick_cnt #(.W(SET_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr_cnt), .adv(adv),
    .limit(tmo_limit), .cnt(cnt), .hit(hit)
  );

  tmo_sticky u_flag (
    .clk(clk), .rst(rst), .set(expire), .clr(tmo_clr), .q(tmo_irq)
  );
endmodule

// File: rtl/i2c_tmo_watch_chk.sv
module i2c_tmo_watch_chk
  import i2c_tmo_pkg::*;
#(
  parameter int SET_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [SET_W-1:0] tmo_limit,
  input logic             start_done,
  input logic             stop_seen,
  input logic             tmo_clr,
  input logic             tmo_irq,
  input logic             expire,
  input logic [SET_W-1:0] cnt,
  input seq_state_e       seq_st
);
  AST_ZERO_LIMIT_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (tmo_limit == '0 && !tmo_irq) |=> !tmo_irq);  // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tmo_irq && !tmo_clr) |=> tmo_irq);  // R9

  AST_SET_OVER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    expire |=> tmo_irq);  // R9

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (tmo_clr && !expire) |=> !tmo_irq);  // R9

  AST_DONE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    ((start_done || stop_seen) && !tmo_irq) |=> !tmo_irq);  // R8

  AST_HOLD_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (seq_st == SQ_HOLD_START || seq_st == SQ_HOLD_STOP) |-> (cnt == '0));  // R5

  AST_EXPIRE_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    expire |-> (cnt == tmo_limit));  // R1

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (!tmo_irq && seq_st == SQ_IDLE));  // R10
endmodule

bind i2c_tmo_watch i2c_tmo_watch_chk #(.SET_W(SET_W)) u_chk (
  .clk(clk), .rst(rst), .tmo_limit(tmo_limit),
  .start_done(start_done), .stop_seen(stop_seen), .tmo_clr(tmo_clr),
  .tmo_irq(tmo_irq), .expire(expire), .cnt(cnt), .seq_st(seq_st)
);

// File: tb/i2c_tmo_watch_tb.sv
`timescale 1ns/1ps
module i2c_tmo_watch_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tmo_limit = 8'd0;
  logic       bit_tick = 0, start_req = 0, stop_req = 0, other_busy = 0;
  logic       scl_in = 1, xfer_active = 0, ack_low_end = 0;
  logic       start_done = 0, stop_seen = 0, tmo_clr = 0;
  logic       tmo_irq;
  int         n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  i2c_tmo_watch dut_i (
    .clk(clk), .rst(rst), .tmo_limit(tmo_limit), .bit_tick(bit_tick),
    .start_req(start_req), .stop_req(stop_req), .other_busy(other_busy),
    .scl_in(scl_in), .xfer_active(xfer_active), .ack_low_end(ack_low_end),
    .start_done(start_done), .stop_seen(stop_seen), .tmo_clr(tmo_clr),
    .tmo_irq(tmo_irq)
  );

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (tmo_irq !== exp) begin
      n_bad++;
      $display("FAIL %s: tmo_irq=%0b expected %0b", req, tmo_irq, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_tick = 1;
      @(negedge clk) bit_tick = 0;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_req = 1;
    @(negedge clk) start_req = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_req = 1;
    @(negedge clk) stop_req = 0;
  endtask

  task automatic pulse_ack();
    @(negedge clk) ack_low_end = 1;
    @(negedge clk) ack_low_end = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk) tmo_clr = 1;
    @(negedge clk) tmo_clr = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); check(1'b0, "R10 reset");
  endtask

  task automatic t_start_scl_low();
    tmo_limit = 8'd3; scl_in = 0; other_busy = 0;
    pulse_start();
    ticks(3); check(1'b0, "R1 before terminal");
    ticks(1); check(1'b1, "R1 terminal tick");
    repeat (3) @(negedge clk);
    check(1'b1, "R9 sticky hold");
    clear_flag(); check(1'b0, "R9 clear");
    scl_in = 1;
  endtask

  task automatic t_start_free_then_other();
    tmo_limit = 8'd3; scl_in = 1; other_busy = 0;
    pulse_start();
    ticks(10); check(1'b0, "R3 free bus ticks ignored");
    @(negedge clk) other_busy = 1;
    ticks(3); check(1'b0, "R4 other master before terminal");
    ticks(1); check(1'b1, "R4 other master terminal");
    other_busy = 0;
    clear_flag();
  endtask

  task automatic t_zero_limit();
    tmo_limit = 8'd0; scl_in = 0;
    pulse_start();
    ticks(20); check(1'b0, "R2 setting zero start");
    pulse_stop();
    ticks(20); check(1'b0, "R2 setting zero stop");
    scl_in = 1;
  endtask

  task automatic t_defer_start();
    tmo_limit = 8'd2; scl_in = 0; xfer_active = 1;
    pulse_start();
    @(negedge clk) xfer_active = 0;
    ticks(10); check(1'b0, "R5 deferred start no count");
    pulse_ack();
    ticks(2); check(1'b0, "R5 armed before terminal");
    ticks(1); check(1'b1, "R5 armed terminal");
    scl_in = 1;
    clear_flag();
  endtask

  task automatic t_stop_now();
    tmo_limit = 8'd5; scl_in = 1; other_busy = 0;
    pulse_stop();
    ticks(5); check(1'b0, "R7 stop before terminal");
    ticks(1); check(1'b1, "R7 stop terminal");
    clear_flag();
  endtask

  task automatic t_defer_stop();
    tmo_limit = 8'd1; xfer_active = 1;
    pulse_stop();
    @(negedge clk) xfer_active = 0;
    ticks(5); check(1'b0, "R6 deferred stop no count");
    pulse_ack();
    ticks(1); check(1'b0, "R6 armed before terminal");
    ticks(1); check(1'b1, "R6 armed terminal");
    clear_flag();
  endtask

  task automatic t_complete();
    tmo_limit = 8'd3; scl_in = 0;
    pulse_start();
    ticks(3);
    @(negedge clk) start_done = 1;
    @(negedge clk) start_done = 0;
    ticks(10); check(1'b0, "R8 start completion");
    scl_in = 1;
    tmo_limit = 8'd2;
    pulse_stop();
    ticks(2);
    @(negedge clk) begin bit_tick = 1; stop_seen = 1; end
    @(negedge clk) begin bit_tick = 0; stop_seen = 0; end
    check(1'b0, "R8 completion on terminal tick");
    ticks(5); check(1'b0, "R8 idle after completion");
  endtask

  task automatic t_clear_vs_set();
    tmo_limit = 8'd1; scl_in = 0;
    pulse_start();
    ticks(1);
    @(negedge clk) begin bit_tick = 1; tmo_clr = 1; end
    @(negedge clk) begin bit_tick = 0; tmo_clr = 0; end
    check(1'b1, "R9 set wins over clear");
    scl_in = 1;
    clear_flag(); check(1'b0, "R9 clear after collision");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_start_scl_low();
    t_start_free_then_other();
    t_zero_limit();
    t_defer_start();
    t_stop_now();
    t_defer_stop();
    t_complete();
    t_clear_vs_set();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule